// File: doc/BRIEF.md
# Second-Order Plant Emulator

This block stands in for a physical second-order process inside a digital control loop. Each time the sample strobe is raised, it reads one signed excitation sample and produces one signed response sample. The response is computed from a fixed recursion over the last two excitation samples and the last two response samples. All gains are integers that carry an implicit scale of 10000.

The default gains reproduce the unit-damped plant 1/(s²+s+1) sampled every 0.12 s. The current excitation sample never reaches the current response, so the block adds exactly one sample of transport delay. The gains are elaboration-time parameters. The multiply-accumulate is carried out in a wide signed accumulator. The sum is divided by the scale with truncation toward zero, then clamped to the sample width before it is stored and fed back.

Top module: `plant2_emulator`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every delayed excitation and response value to 0, drives `y_out` to 0 and holds `y_vld` low.
- R2: Internal state and `y_out` change only at a clock edge where `smp_stb` is high. Between strobes, `y_out` holds its value and `x_in` has no effect.
- R3: `y_vld` is high for exactly the one cycle that follows each strobe edge, and `y_out` shows the new response in that same cycle.
- R4: There is no feed-through. The response produced at strobe n uses only the excitations from strobes n-1 and n-2, so the first response after reset is 0 whatever `x_in` is.
- R5: The response is y[n] = (69·x[n-1] + 66·x[n-2] + 18730·y[n-1] − 8869·y[n-2]) / 10000. The sum is formed in a signed accumulator of at least 48 bits, and the division truncates toward zero.
- R6: If the quotient exceeds the signed `DW`-bit range, the stored response clamps to +32767 or −32768 (for `DW`=16). The clamped value, and not a wrapped one, is the value fed back.
- R7: With a constant step of 1000, the response overshoots and then settles to a constant value between 890 and 980. This is a DC gain near 1, less the loss from integer coefficients and truncation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_stb | input | 1 | Sample strobe; one recursion step per cycle it is high |
| x_in | input | DW | Signed excitation sample, taken with the strobe |
| y_out | output | DW | Signed response sample (most recent) |
| y_vld | output | 1 | One-cycle pulse marking a fresh `y_out` |

## Verification
The hardest state to reach is a response that clamps and then feeds the clamped value back through two taps, because only a large and sustained excitation drives the accumulator past the sample range. The stimulus gets there with full-scale steps of both signs. Near full scale, the plant's roughly 16 % overshoot forces several consecutive clamped samples. A drop back to zero afterwards exercises recovery from the saturated history. Idle gaps of varying length between strobes, with `x_in` toggling during them, expose any update that does not wait for the strobe.

// File: rtl/plant2_pkg.sv
package plant2_pkg;
    // Default integer gains, implicit scale of 10000
    localparam int GAIN_X1 = 69;
    localparam int GAIN_X2 = 66;
    localparam int GAIN_Y1 = 18730;
    localparam int GAIN_Y2 = 8869;
    localparam int GAIN_SCALE = 10000;
endpackage

// File: rtl/p2_taps.sv
module p2_taps #(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                adv,
    input  logic signed [W-1:0] din,
    output logic signed [W-1:0] tap1,
    output logic signed [W-1:0] tap2
);
    typedef struct packed {
        logic signed [W-1:0] t1;
        logic signed [W-1:0] t2;
    } taps_t;

    taps_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adv) begin
            st_d.t1 = din;
            st_d.t2 = st_q.t1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign tap1 = st_q.t1;
    assign tap2 = st_q.t2;

    // R5: one-sample and two-sample delays shift together on a strobe
    a_r5_tap_shift: assert property (@(posedge clk) disable iff (rst)
        adv |=> (tap1 == $past(din)) && (tap2 == $past(tap1)));
    // R2: taps hold without a strobe
    a_r2_tap_hold: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(tap1) && $stable(tap2));
endmodule

// File: rtl/p2_mac.sv
module p2_mac #(
    parameter int DW   = 16,
    parameter int ACCW = 48,
    parameter int KX1  = 69,
    parameter int KX2  = 66,
    parameter int KY1  = 18730,
    parameter int KY2  = 8869
) (
    input  logic signed [DW-1:0]   x1,
    input  logic signed [DW-1:0]   x2,
    input  logic signed [DW-1:0]   y1,
    input  logic signed [DW-1:0]   y2,
    output logic signed [ACCW-1:0] acc
);
    localparam int EXT = ACCW - DW;
    localparam logic signed [ACCW-1:0] CX1 = ACCW'(KX1);
    localparam logic signed [ACCW-1:0] CX2 = ACCW'(KX2);
    localparam logic signed [ACCW-1:0] CY1 = ACCW'(KY1);
    localparam logic signed [ACCW-1:0] CY2 = ACCW'(KY2);

    logic signed [ACCW-1:0] ex1, ex2, ey1, ey2;

    always_comb begin
        ex1 = {{EXT{x1[DW-1]}}, x1};
        ex2 = {{EXT{x2[DW-1]}}, x2};
        ey1 = {{EXT{y1[DW-1]}}, y1};
        ey2 = {{EXT{y2[DW-1]}}, y2};
        acc = CX1 * ex1 + CX2 * ex2 + CY1 * ey1 - CY2 * ey2;
    end
endmodule

// File: rtl/p2_rescale.sv
module p2_rescale #(
    parameter int ACCW  = 48,
    parameter int DW    = 16,
    parameter int SCALE = 10000
) (
    input  logic signed [ACCW-1:0] acc,
    output logic signed [DW-1:0]   y_sat,
    output logic                   clip_hi,
    output logic                   clip_lo
);
    localparam logic signed [ACCW-1:0] DIV  = ACCW'(SCALE);
    localparam logic signed [ACCW-1:0] MAXV = ACCW'((64'sd1 <<< (DW-1)) - 1);
    localparam logic signed [ACCW-1:0] MINV = -(ACCW'(64'sd1 <<< (DW-1)));

    logic signed [ACCW-1:0] quo;

    always_comb begin
        quo     = acc / DIV;  // signed division truncates toward zero
        clip_hi = (quo > MAXV);
        clip_lo = (quo < MINV);
        if (clip_hi)      y_sat = MAXV[DW-1:0];
        else if (clip_lo) y_sat = MINV[DW-1:0];
        else              y_sat = quo[DW-1:0];
    end
endmodule

// File: rtl/plant2_emulator.sv
module plant2_emulator
    import plant2_pkg::*;
#(
    parameter int DW    = 16,
    parameter int ACCW  = 48,
    parameter int KX1   = GAIN_X1,
    parameter int KX2   = GAIN_X2,
    parameter int KY1   = GAIN_Y1,
    parameter int KY2   = GAIN_Y2,
    parameter int SCALE = GAIN_SCALE
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 smp_stb,
    input  logic signed [DW-1:0] x_in,
    output logic signed [DW-1:0] y_out,
    output logic                 y_vld
);
    localparam logic signed [DW-1:0] Y_MAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic signed [DW-1:0] Y_MIN = {1'b1, {(DW-1){1'b0}}};

    typedef struct packed {
        logic vld;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic signed [DW-1:0]   x1, x2, y1, y2, y_new;
    logic signed [ACCW-1:0] acc;
    logic                   clip_hi, clip_lo;

    p2_taps #(.W(DW)) u_xtaps (
        .clk(clk), .rst(rst), .adv(smp_stb), .din(x_in), .tap1(x1), .tap2(x2)
    );

    p2_taps #(.W(DW)) u_ytaps (
        .clk(clk), .rst(rst), .adv(smp_stb), .din(y_new), .tap1(y1), .tap2(y2)
    );

    p2_mac #(.DW(DW), .ACCW(ACCW), .KX1(KX1), .KX2(KX2), .KY1(KY1), .KY2(KY2)) u_mac (
        .x1(x1), .x2(x2), .y1(y1), .y2(y2), .acc(acc)
    );

    p2_rescale #(.ACCW(ACCW), .DW(DW), .SCALE(SCALE)) u_rescale (
        .acc(acc), .y_sat(y_new), .clip_hi(clip_hi), .clip_lo(clip_lo)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.vld = smp_stb;
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '0;
        else     ctl_q <= ctl_d;
    end

    assign y_out = y1;
    assign y_vld = ctl_q.vld;

    // R1: reset clears output and valid
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (y_out == '0) && !y_vld);
    // R2: output stable between strobes
    a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !smp_stb |=> $stable(y_out));
    // R3: valid pulse follows each strobe
    a_r3_vld_pulse: assert property (@(posedge clk) disable iff (rst)
        smp_stb |=> y_vld);
    a_r3_vld_only: assert property (@(posedge clk) disable iff (rst)
        !smp_stb |=> !y_vld);
    // R6: clamping to the extremes of the sample range
    a_r6_clip_high: assert property (@(posedge clk) disable iff (rst)
        (smp_stb && clip_hi) |=> (y_out == Y_MAX));
    a_r6_clip_low: assert property (@(posedge clk) disable iff (rst)
        (smp_stb && clip_lo) |=> (y_out == Y_MIN));
endmodule

// File: tb/tb_plant2_emulator.sv
module tb_plant2_emulator;
    localparam int DW = 16;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 smp_stb = 1'b0;
    logic signed [DW-1:0] x_in = '0;
    logic signed [DW-1:0] y_out;
    logic                 y_vld;

    plant2_emulator dut (
        .clk(clk), .rst(rst), .smp_stb(smp_stb), .x_in(x_in),
        .y_out(y_out), .y_vld(y_vld)
    );

    always #10 clk = ~clk;  // 50 MHz

    int n_checks = 0;
    int n_fails  = 0;
    longint mx1, mx2, my1, my2;
    int exp_q[$];
    string req_q[$];
    int last_y = 0;
    bit in_reset = 1'b1;
    bit first_after_rst = 1'b0;

    task automatic chk(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint model_step(input longint x);
        longint s, q;
        s = 69 * mx1 + 66 * mx2 + 18730 * my1 - 8869 * my2;
        q = s / 10000;
        if (q > 32767) q = 32767;
        if (q < -32768) q = -32768;
        mx2 = mx1; mx1 = x;
        my2 = my1; my1 = q;
        return q;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        in_reset = 1'b1;
        rst = 1'b1;
        smp_stb = 1'b0;
        x_in = 16'sd1234;
        repeat (2) @(negedge clk);
        mx1 = 0; mx2 = 0; my1 = 0; my2 = 0;
        chk("R1 reset output", y_out, 0);
        chk("R1 reset valid", y_vld, 0);
        rst = 1'b0;
        last_y = 0;
        first_after_rst = 1'b1;
        in_reset = 1'b0;
    endtask

    // driver: one strobe, then idle gap with x_in toggled (R2)
    task automatic send(input int x, input int gap);
        longint e;
        @(negedge clk);
        x_in = DW'(x);
        smp_stb = 1'b1;
        e = model_step(x);
        exp_q.push_back(int'(e));
        req_q.push_back(first_after_rst ? "R4 no feed-through" : "R5 recursion");
        first_after_rst = 1'b0;
        @(negedge clk);
        smp_stb = 1'b0;
        for (int i = 0; i < gap; i++) begin
            x_in = DW'(x ^ 32'h5a5a);
            @(negedge clk);
        end
    endtask

    // monitor: compares on valid, checks hold otherwise
    always @(negedge clk) begin
        if (!in_reset && !rst) begin
            if (y_vld) begin
                if (exp_q.size() == 0) begin
                    chk("R3 unexpected valid", 1, 0);
                end else begin
                    int e;
                    string r;
                    e = exp_q.pop_front();
                    r = req_q.pop_front();
                    chk(r, y_out, e);
                    last_y = e;
                end
            end else begin
                chk("R2 hold between strobes", y_out, last_y);
            end
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin : stim
        int y_prev;
        mx1 = 0; mx2 = 0; my1 = 0; my2 = 0;
        do_reset();

        // R7: step of 1000 with varied gaps
        for (int k = 0; k < 300; k++) send(1000, k % 3);
        repeat (3) @(negedge clk);
        y_prev = y_out;
        send(1000, 1);
        repeat (2) @(negedge clk);
        chk("R7 settled constant", y_out, y_prev);
        chk("R7 gain lower bound", (y_out >= 890) ? 1 : 0, 1);
        chk("R7 gain upper bound", (y_out <= 980) ? 1 : 0, 1);

        // R4: impulse after reset; first output 0, second carries 69*x/10000
        do_reset();
        send(5000, 0);
        send(0, 2);
        send(0, 0);
        for (int k = 0; k < 60; k++) send(0, 1);

        // R6: full-scale positive step clamps, then recovery from zero input
        do_reset();
        for (int k = 0; k < 120; k++) send(32767, 0);
        for (int k = 0; k < 120; k++) send(0, 0);

        // R6: full-scale negative step clamps at the low end
        do_reset();
        for (int k = 0; k < 120; k++) send(-32768, 0);

        // R5: alternating-sign pattern, truncation toward zero on negatives
        do_reset();
        for (int k = 0; k < 100; k++) send((k % 7 < 3) ? -777 - 13 * k : 451 + 9 * k, k % 2);

        // R1: reset mid-run discards history
        do_reset();
        send(300, 0);
        send(300, 0);

        repeat (4) @(negedge clk);
        chk("R3 scoreboard drained", exp_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule